// File: doc/BRIEF.md
# Multiplexed BCD Preset Load Sequencer

This block controls preset entry for a four-digit decade counter and its compare register. Both share a single 4-bit BCD port with the multiplexed display scan. Two three-level controls select the operation. One requests a counter load and the other a register load. Driving a control low selects a quiet mode: the counter-side control floats the port, and the register-side control blanks the display. Leaving a control open gives normal operation.

A load starts when either control rises to its high level. The block then takes the digit scan away from the external scan tick, restarts it at the most significant digit and steps it with an internal fixed-rate timer. One BCD digit is sampled in the last clock of each digit strobe. After the fourth digit, the assembled word is handed to the counter, the register, or both, as a one-cycle strobe. At that point the block checks the controls again and either runs another full cycle or returns to normal scanning. It also drives three outputs: a count-inhibit, a port-direction enable and a flags-invalid indication, which the counter and comparator outside the block use.

Top module: `preload_seq`

## Requirements
- R1: Control encoding is 2'b00 low, 2'b01 open, 2'b10 high, and 2'b11 is also treated as open. `portDrive` is 1 only when neither control is low or high and no load sequence (including its transfer cycle) is active.
- R2: In normal operation `digitSel` is one-hot, with bit 3 for D4 (most significant) down to bit 0 for D1. After reset it shows D4. A clock with `scanTick`=1 moves it D4→D3→D2→D1→D4, and a clock without `scanTick` leaves it unchanged.
- R3: While the register control is low and no sequence runs, `digitSel` is all zero and the scan is held at D4. Releasing the control therefore shows D4 at once.
- R4: The clock edge that first sees a control at high starts a sequence, and D4 is shown in the following cycle. Each digit is strobed for DIGIT_CYC cycles in the order D4, D3, D2, D1, and `scanTick` has no effect during the sequence.
- R5: `bcdIn` is sampled in the last cycle of each digit strobe. The D4 digit lands in bits 15:12 of the loaded word and D1 in bits 3:0.
- R6: `cntLoadStb` and `regLoadStb` pulse for one cycle, NDIG*DIGIT_CYC cycles after the first D4 cycle, carrying the whole word in `cntLoadVal` and `regLoadVal`. Each pulses only if its own control requested the cycle, and both carry the same word when both did.
- R7: `countInhibit` is 1 from the first D4 cycle up to and including the counter strobe cycle when the counter is being loaded. It stays 0 for a register-only load.
- R8: `flagsInvalid` is 1 from the first D4 cycle up to and including the transfer cycle, and 0 otherwise.
- R9: If either control is still high at the end of a cycle, another full cycle runs with the same timing. Otherwise the scan returns to normal at D4 and follows `scanTick` again.
- R10: A high pulse of a single clock is latched and runs exactly one full cycle with one transfer.
- R11: Holding the counter control low floats the port and nothing else changes: no strobe, no inhibit, no invalid flag, and the scan still follows `scanTick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lcLevel | input | 2 | Counter-load control level (00 low, 01/11 open, 10 high) |
| lrLevel | input | 2 | Register-load control level (00 low, 01/11 open, 10 high) |
| scanTick | input | 1 | External scan step pulse, used only in normal mode |
| bcdIn | input | 4 | BCD digit read from the shared port |
| digitSel | output | 4 | One-hot digit strobe, bit 3 = D4 |
| portDrive | output | 1 | 1 = port drives latch data out, 0 = port is high impedance |
| countInhibit | output | 1 | Blocks counting while the counter is being preset |
| flagsInvalid | output | 1 | Zero and equal flags are not valid |
| cntLoadStb | output | 1 | One-cycle counter preset strobe |
| cntLoadVal | output | 16 | Counter preset word, D4 in bits 15:12 |
| regLoadStb | output | 1 | One-cycle register load strobe |
| regLoadVal | output | 16 | Register load word, D4 in bits 15:12 |

## Verification
Every cycle, the assertions check the relations between the control outputs. The strobe stays one-hot. The port never drives while flags are invalid. A strobe is always covered by the invalid flag, and a counter strobe also by the inhibit. A sequence always opens on D4 after a high control level, and no strobe appears without a sequence. The scenarios in the bench are the only place where the assembled digit order and values can be seen. They also show the exact cycle of each strobe, repeats while a control stays high, latching of a one-clock pulse, display blanking and the return to the external scan.

// File: rtl/preload_pkg.sv
package preload_pkg;
  localparam int NDIG = 4;
  localparam int DW   = 4;
  localparam int PW   = $clog2(NDIG);
  localparam int WW   = NDIG * DW;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_OPEN = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_ALT  = 2'b11
  } level_e;

  typedef enum logic {ST_SCAN = 1'b0, ST_LOAD = 1'b1} seqState_e;

  typedef struct packed {
    logic          capture;
    logic [PW-1:0] capIdx;
    logic          xfer;
    logic          doCnt;
    logic          doReg;
  } ctrlStb_t;
endpackage

// File: rtl/preload_ctrl.sv
module preload_ctrl
  import preload_pkg::*;
#(
  parameter int DIGIT_CYC = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      lcLevel,
  input  logic [1:0]      lrLevel,
  input  logic            scanTick,
  output ctrlStb_t        stb,
  output logic [NDIG-1:0] digitSel,
  output logic            portDrive,
  output logic            countInhibit,
  output logic            flagsInvalid
);
  localparam int TW = $clog2(DIGIT_CYC + 1);
  localparam logic [PW-1:0] LAST = PW'(NDIG - 1);

  seqState_e     state;
  logic [PW-1:0] phase;
  logic [TW-1:0] timer;
  logic          doCnt, doReg;
  logic          pendC, pendR;
  logic          lcHighD, lrHighD;
  logic          postCnt, postAny;

  logic lcHigh, lrHigh, lcLow, lrLow;
  logic reqC, reqR, contC, contR;
  logic loading, digitEnd, cycleEnd, showDigits;

  always_comb begin
    lcHigh   = (lcLevel == LVL_HIGH);
    lrHigh   = (lrLevel == LVL_HIGH);
    lcLow    = (lcLevel == LVL_LOW);
    lrLow    = (lrLevel == LVL_LOW);
    reqC     = pendC | (lcHigh & ~lcHighD);
    reqR     = pendR | (lrHigh & ~lrHighD);
    contC    = reqC | lcHigh;
    contR    = reqR | lrHigh;
    loading  = (state == ST_LOAD);
    digitEnd = loading && (timer == TW'(DIGIT_CYC - 1));
    cycleEnd = digitEnd && (phase == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_SCAN;
      phase   <= LAST;
      timer   <= '0;
      doCnt   <= 1'b0;
      doReg   <= 1'b0;
      pendC   <= 1'b0;
      pendR   <= 1'b0;
      lcHighD <= 1'b0;
      lrHighD <= 1'b0;
      postCnt <= 1'b0;
      postAny <= 1'b0;
    end else begin
      lcHighD <= lcHigh;
      lrHighD <= lrHigh;
      postCnt <= cycleEnd & doCnt;
      postAny <= cycleEnd;
      case (state)
        ST_SCAN: begin
          if (reqC || reqR) begin
            state <= ST_LOAD;
            doCnt <= reqC;
            doReg <= reqR;
            phase <= LAST;
            timer <= '0;
            pendC <= 1'b0;
            pendR <= 1'b0;
          end else if (lrLow) begin
            phase <= LAST;
          end else if (scanTick) begin
            phase <= (phase == '0) ? LAST : phase - 1'b1;
          end
        end
        default: begin
          if (!digitEnd) begin
            timer <= timer + 1'b1;
            pendC <= reqC;
            pendR <= reqR;
          end else begin
            timer <= '0;
            if (!cycleEnd) begin
              phase <= phase - 1'b1;
              pendC <= reqC;
              pendR <= reqR;
            end else begin
              phase <= LAST;
              pendC <= 1'b0;
              pendR <= 1'b0;
              if (contC || contR) begin
                doCnt <= contC;
                doReg <= contR;
              end else begin
                state <= ST_SCAN;
              end
            end
          end
        end
      endcase
    end
  end

  assign showDigits = loading || !lrLow;

  for (genvar g = 0; g < NDIG; g++) begin : g_sel
    assign digitSel[g] = showDigits && (phase == PW'(g));
  end

  always_comb begin
    stb.capture  = digitEnd;
    stb.capIdx   = phase;
    stb.xfer     = cycleEnd;
    stb.doCnt    = doCnt;
    stb.doReg    = doReg;
    portDrive    = !loading && !postAny && !lcLow && !lrLow && !lcHigh && !lrHigh;
    countInhibit = (loading && doCnt) || postCnt;
    flagsInvalid = loading || postAny;
  end
endmodule

// File: rtl/preload_dp.sv
module preload_dp
  import preload_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] bcdIn,
  input  ctrlStb_t      stb,
  output logic          cntLoadStb,
  output logic [WW-1:0] cntLoadVal,
  output logic          regLoadStb,
  output logic [WW-1:0] regLoadVal
);
  logic [WW-1:0] holdWord;
  logic [WW-1:0] nextWord;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign nextWord[g*DW +: DW] =
      (stb.capture && stb.capIdx == PW'(g)) ? bcdIn : holdWord[g*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdWord   <= '0;
      cntLoadStb <= 1'b0;
      regLoadStb <= 1'b0;
      cntLoadVal <= '0;
      regLoadVal <= '0;
    end else begin
      holdWord   <= nextWord;
      cntLoadStb <= stb.xfer && stb.doCnt;
      regLoadStb <= stb.xfer && stb.doReg;
      if (stb.xfer && stb.doCnt) cntLoadVal <= nextWord;
      if (stb.xfer && stb.doReg) regLoadVal <= nextWord;
    end
  end
endmodule

// File: rtl/preload_seq.sv
module preload_seq
  import preload_pkg::*;
#(
  parameter int DIGIT_CYC = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      lcLevel,
  input  logic [1:0]      lrLevel,
  input  logic            scanTick,
  input  logic [DW-1:0]   bcdIn,
  output logic [NDIG-1:0] digitSel,
  output logic            portDrive,
  output logic            countInhibit,
  output logic            flagsInvalid,
  output logic            cntLoadStb,
  output logic [WW-1:0]   cntLoadVal,
  output logic            regLoadStb,
  output logic [WW-1:0]   regLoadVal
);
  ctrlStb_t stb;

  preload_ctrl #(.DIGIT_CYC(DIGIT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .lcLevel(lcLevel), .lrLevel(lrLevel),
    .scanTick(scanTick), .stb(stb), .digitSel(digitSel),
    .portDrive(portDrive), .countInhibit(countInhibit),
    .flagsInvalid(flagsInvalid)
  );

  preload_dp u_dp (
    .clk(clk), .rstN(rstN), .bcdIn(bcdIn), .stb(stb),
    .cntLoadStb(cntLoadStb), .cntLoadVal(cntLoadVal),
    .regLoadStb(regLoadStb), .regLoadVal(regLoadVal)
  );
endmodule

// File: rtl/preload_chk.sv
module preload_chk
  import preload_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      lcLevel,
  input logic [1:0]      lrLevel,
  input logic [NDIG-1:0] digitSel,
  input logic            portDrive,
  input logic            countInhibit,
  input logic            flagsInvalid,
  input logic            cntLoadStb,
  input logic            regLoadStb
);
  localparam logic [NDIG-1:0] SEL_TOP = NDIG'(1) << (NDIG - 1);

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(digitSel));

  p_port_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    flagsInvalid |-> !portDrive);

  p_blank_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lrLevel == LVL_LOW && !flagsInvalid) |-> (digitSel == '0));

  p_start_top_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsInvalid) |-> (digitSel == SEL_TOP));

  p_start_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsInvalid) |-> $past(lcLevel == LVL_HIGH || lrLevel == LVL_HIGH));

  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cntLoadStb || regLoadStb) |=> !(cntLoadStb || regLoadStb));

  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rstN)
    cntLoadStb |-> countInhibit);

  p_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cntLoadStb || regLoadStb) |-> flagsInvalid);

  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rstN)
    !flagsInvalid |=> !(cntLoadStb || regLoadStb));
endmodule

bind preload_seq preload_chk u_chk (.*);

// File: tb/tb_preload_seq.sv
module tb_preload_seq;
  import preload_pkg::*;

  localparam int DC  = 4;
  localparam int CYC = NDIG * DC;

  logic            clk = 1'b0;
  logic            rstN;
  logic [1:0]      lcLevel, lrLevel;
  logic            scanTick;
  logic [DW-1:0]   bcdIn;
  logic [NDIG-1:0] digitSel;
  logic            portDrive, countInhibit, flagsInvalid;
  logic            cntLoadStb, regLoadStb;
  logic [WW-1:0]   cntLoadVal, regLoadVal;
  logic [WW-1:0]   curVal;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  preload_seq #(.DIGIT_CYC(DC)) dut (
    .clk(clk), .rstN(rstN), .lcLevel(lcLevel), .lrLevel(lrLevel),
    .scanTick(scanTick), .bcdIn(bcdIn), .digitSel(digitSel),
    .portDrive(portDrive), .countInhibit(countInhibit),
    .flagsInvalid(flagsInvalid), .cntLoadStb(cntLoadStb),
    .cntLoadVal(cntLoadVal), .regLoadStb(regLoadStb), .regLoadVal(regLoadVal)
  );

  // thumbwheel model: the strobed digit drives its own nibble
  always_comb begin
    bcdIn = '0;
    for (int d = 0; d < NDIG; d++)
      if (digitSel[d]) bcdIn = curVal[d*DW +: DW];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NDIG-1:0] selOf(input int idx);
    return NDIG'(1) << idx;
  endfunction

  task automatic runLoad(input bit useC, input bit useR, input logic [WW-1:0] v,
                         input int hold, input string tag);
    int cycles = 1 + (hold - 1) / CYC;
    int window = cycles * CYC + 3;
    bit okSel = 1, okC = 1, okR = 1, okInh = 1, okFl = 1, okPort = 1, okVal = 1;
    logic [31:0] aSel = 0, eSel = 0, aVal = 0;
    int nC = 0, nR = 0;
    curVal = v;
    if (useC) lcLevel = LVL_HIGH;
    if (useR) lrLevel = LVL_HIGH;
    scanTick = 1'b1;
    for (int i = 1; i <= window; i++) begin
      int k;
      bit expStb, expFl;
      @(negedge clk);
      k = i - 1;
      expStb = (k > 0) && (k % CYC == 0) && (k / CYC <= cycles);
      expFl  = (k <= cycles * CYC);
      if (k < cycles * CYC) begin
        logic [NDIG-1:0] es = selOf(NDIG - 1 - (k % CYC) / DC);
        if (digitSel !== es && okSel) begin okSel = 0; aSel = digitSel; eSel = es; end
        if (portDrive !== 1'b0) okPort = 0;
      end
      if (cntLoadStb !== (expStb && useC)) okC = 0;
      if (regLoadStb !== (expStb && useR)) okR = 0;
      if (cntLoadStb === 1'b1) begin nC++; if (cntLoadVal !== v) begin okVal = 0; aVal = cntLoadVal; end end
      if (regLoadStb === 1'b1) begin nR++; if (regLoadVal !== v) begin okVal = 0; aVal = regLoadVal; end end
      if (countInhibit !== (expFl && useC)) okInh = 0;
      if (flagsInvalid !== expFl) okFl = 0;
      if (i == hold) begin lcLevel = LVL_OPEN; lrLevel = LVL_OPEN; end
      if (k == cycles * CYC - 1) scanTick = 1'b0;
    end
    chk(okSel,  {"R4 digit order/timing ", tag}, aSel, eSel);
    chk(okPort, {"R1 port off in load ", tag}, 32'(portDrive), 0);
    chk(okC && nC == (useC ? cycles : 0), {"R6/R9/R10 counter strobes ", tag}, nC, useC ? cycles : 0);
    chk(okR && nR == (useR ? cycles : 0), {"R6/R9 register strobes ", tag}, nR, useR ? cycles : 0);
    chk(okVal, {"R5 loaded word ", tag}, aVal, v);
    chk(okInh, {"R7 count inhibit ", tag}, 32'(countInhibit), 32'(useC));
    chk(okFl,  {"R8 flags invalid ", tag}, 32'(flagsInvalid), 0);
    // R9: normal scan resumes at D4 and follows the tick
    chk(digitSel === selOf(NDIG - 1), {"R9 back at D4 ", tag}, digitSel, selOf(NDIG - 1));
    scanTick = 1'b1;
    @(negedge clk);
    scanTick = 1'b0;
    chk(digitSel === selOf(NDIG - 2), {"R9 scan follows tick ", tag}, digitSel, selOf(NDIG - 2));
    scanTick = 1'b1;
    repeat (3) @(negedge clk);
    scanTick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int idx;
    rstN = 1'b0; lcLevel = LVL_OPEN; lrLevel = LVL_OPEN; scanTick = 1'b0; curVal = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk(digitSel === selOf(NDIG - 1), "R2 reset at D4", digitSel, selOf(NDIG - 1));
    chk(portDrive === 1'b1, "R1 reset port drives", 32'(portDrive), 1);
    chk(!cntLoadStb && !regLoadStb, "R6 reset no strobe", 32'({cntLoadStb, regLoadStb}), 0);
    chk(countInhibit === 1'b0, "R7 reset inhibit", 32'(countInhibit), 0);
    chk(flagsInvalid === 1'b0, "R8 reset flags", 32'(flagsInvalid), 0);

    // R2 normal scan rotation
    for (int i = 1; i <= 8; i++) begin
      scanTick = 1'b1;
      @(negedge clk);
      scanTick = 1'b0;
      idx = NDIG - 1 - (i % NDIG);
      chk(digitSel === selOf(idx), "R2 scan step", digitSel, selOf(idx));
    end
    @(negedge clk);
    chk(digitSel === selOf(NDIG - 1), "R2 hold without tick", digitSel, selOf(NDIG - 1));

    // R3 display off
    scanTick = 1'b1;
    @(negedge clk);
    lrLevel = LVL_LOW;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(digitSel === '0, "R3 blank while off", digitSel, 0);
      chk(portDrive === 1'b0, "R1 port off while display off", 32'(portDrive), 0);
    end
    scanTick = 1'b0;
    lrLevel = LVL_OPEN;
    #1;
    chk(digitSel === selOf(NDIG - 1), "R3 resumes at D4", digitSel, selOf(NDIG - 1));
    @(negedge clk);

    // R1 port drive over non-high level combinations
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a == 2 || b == 2) continue;
        lcLevel = 2'(a);
        lrLevel = 2'(b);
        #1;
        chk(portDrive === (a != 0 && b != 0), "R1 port drive matrix",
            32'(portDrive), 32'(a != 0 && b != 0));
        @(negedge clk);
      end
    end
    lcLevel = LVL_OPEN; lrLevel = LVL_OPEN;
    @(negedge clk);

    // R11 counter control low changes nothing but the port
    lcLevel = LVL_LOW;
    for (int i = 1; i <= 6; i++) begin
      scanTick = 1'b1;
      @(negedge clk);
      scanTick = 1'b0;
      idx = NDIG - 1 - (i % NDIG);
      chk(digitSel === selOf(idx), "R11 scan continues", digitSel, selOf(idx));
      chk(!cntLoadStb && !regLoadStb && !flagsInvalid && !countInhibit && !portDrive,
          "R11 only port floated",
          32'({cntLoadStb, regLoadStb, flagsInvalid, countInhibit, portDrive}), 0);
    end
    lcLevel = LVL_OPEN;
    for (int i = 0; i < NDIG; i++) begin
      @(negedge clk);
      if (digitSel === selOf(NDIG - 1)) break;
      scanTick = 1'b1;
      @(negedge clk);
      scanTick = 1'b0;
    end
    @(negedge clk);

    // load scenarios
    runLoad(1, 0, 16'h1234, 1, "cnt one-clock pulse R10");
    runLoad(0, 1, 16'h9870, 3, "reg only");
    runLoad(1, 1, 16'h4095, 2, "both");
    runLoad(1, 0, 16'h5959, CYC + 4, "cnt held two cycles");
    runLoad(0, 1, 16'h0001, 2 * CYC + 1, "reg held three cycles");
    for (int d = 0; d < 10; d++) begin
      logic [3:0] x = 4'(d);
      logic [3:0] y = 4'(9 - d);
      runLoad(d[0], ~d[0] | d[1], {x, y, y, x}, 1 + (d % 3), "digit sweep");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule